// File: doc/BRIEF.md
# Dual-Verdict Packet Hold and Dispatch

This block holds data packets, arriving as a stream of fixed-size flits, in an on-chip flit FIFO. It releases each packet only after two independent decisions for that packet are known. The first is a forwarding decision from a flow lookup: a hit or a miss, a drop action, and an egress port. The second is a security decision assembled from the votes of several filter cores. Both kinds of decision are queued in arrival order, so either may come before or after the packet it refers to. The block pairs them with packets first in, first out.

When a decision pair is at the head of both queues, the dispatcher chooses one of three fates for the oldest packet:
- It discards the packet. This happens when any enabled core votes illegal, when the lookup hit an entry whose action is drop, or when a sequence tag disagrees. The discard drains the packet's flits silently, one per cycle.
- It streams the packet to the egress port named by the lookup.
- It streams the packet to the controller port when the lookup missed.

Top module: `verdict_hold_dispatch`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` is 0, and `in_ready`, `lk_ready` and `sec_ready` are 1.
- R2: An input flit is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 whenever PKT_DEPTH flits are held, and `in_valid` has no effect while `in_ready` is 0.
- R3: The security decision is drop when at least one bit of `sec_illegal` is 1 with the same bit of `core_en` set. Both vectors are sampled when the decision is accepted.
- R4: A core whose `core_en` bit is 0 counts as a legal vote, whatever its `sec_illegal` bit.
- R5: A packet that is discarded produces no output flit. Its flits are removed from the FIFO, and the next packet is then served normally.
- R6: A legal packet whose lookup hit (`lk_hit`=1, `lk_drop`=0) leaves with `out_port` equal to `lk_port` and `out_to_ctrl`=0. The flit data and order are unchanged, and `out_last` is 1 on the final flit only.
- R7: A legal packet whose lookup hit with `lk_drop`=1 is discarded.
- R8: A legal packet whose lookup missed (`lk_hit`=0) leaves with `out_to_ctrl`=1 and `out_port`=0.
- R9: Lookup and security decisions are each queued up to VQ_DEPTH deep and applied to packets in arrival order. A decision may be accepted before or after its packet.
- R10: Packets are numbered 0, 1, 2, ... modulo 2^TAG_W in arrival order. If `lk_tag` or `sec_tag` of the pair at the head differs from the head packet's number, the packet is discarded.
- R11: When a packet is already fully buffered, its first flit appears on the output two cycles after the edge that accepts the later of its two decisions. After that, buffered flits leave one per cycle.
- R12: `out_port` and `out_to_ctrl` do not change between flits of the same packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input flit valid |
| in_data | input | FLIT_W | Input flit payload |
| in_last | input | 1 | Marks the last flit of a packet |
| in_ready | output | 1 | Flit FIFO can accept a flit |
| lk_valid | input | 1 | Lookup decision valid |
| lk_tag | input | TAG_W | Packet number the lookup refers to |
| lk_hit | input | 1 | A flow entry matched |
| lk_drop | input | 1 | Matched action is drop |
| lk_port | input | PORT_W | Egress port of the matched action |
| lk_ready | output | 1 | Lookup queue has room |
| sec_valid | input | 1 | Security votes valid |
| sec_tag | input | TAG_W | Packet number the votes refer to |
| sec_illegal | input | N_CORES | One illegal vote per filter core |
| core_en | input | N_CORES | Enable per filter core |
| sec_ready | output | 1 | Security queue has room |
| out_valid | output | 1 | Output flit valid |
| out_data | output | FLIT_W | Output flit payload |
| out_last | output | 1 | Last flit of the outgoing packet |
| out_port | output | PORT_W | Egress port index |
| out_to_ctrl | output | 1 | Flit is bound for the controller port |

## Verification
The bench builds the block with FLIT_W=16, PKT_DEPTH=16, VQ_DEPTH=4, TAG_W=4, N_PORTS=4 and N_CORES=3. With a 16-flit buffer, one 16-flit packet fills the FIFO, so backpressure and ignored pushes can be checked. Three cores are enough to mix enabled and disabled illegal votes. Four egress ports let every port index appear. The 4-bit tag with only a handful of packets in flight keeps tag mismatches cheap to provoke.

// File: rtl/hd_pkg.sv
package hd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SEND    = 2'd1,
    ST_DISCARD = 2'd2
  } hd_state_e;
endpackage

// File: rtl/hd_fifo.sv
module hd_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  // storage has no reset so that a RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/hd_vote_merge.sv
module hd_vote_merge #(
  parameter int N_CORES = 3
) (
  input  logic [N_CORES-1:0] illegal,
  input  logic [N_CORES-1:0] enable,
  output logic               drop
);
  logic [N_CORES-1:0] counted;

  // a disabled core contributes a legal vote
  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    assign counted[i] = illegal[i] & enable[i];
  end

  assign drop = |counted;
endmodule

// File: rtl/hd_dispatch.sv
module hd_dispatch
  import hd_pkg::*;
#(
  parameter int FLIT_W = 16,
  parameter int TAG_W  = 4,
  parameter int PORT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_empty,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              lk_hit,
  input  logic              lk_drop,
  input  logic [PORT_W-1:0] lk_port,
  output logic              lk_pop,
  input  logic              sec_empty,
  input  logic [TAG_W-1:0]  sec_tag,
  input  logic              sec_drop,
  output logic              sec_pop,
  input  logic              flit_empty,
  input  logic [FLIT_W-1:0] flit_data,
  input  logic              flit_last,
  output logic              flit_pop,
  output logic              out_valid,
  output logic [FLIT_W-1:0] out_data,
  output logic              out_last,
  output logic [PORT_W-1:0] out_port,
  output logic              out_to_ctrl
);
  hd_state_e         st;
  logic [TAG_W-1:0]  head_tag;
  logic [PORT_W-1:0] dest_port;
  logic              dest_ctrl;
  logic              decide, tag_ok, kill, to_ctrl;

  assign decide   = (st == ST_IDLE) && !lk_empty && !sec_empty;
  assign tag_ok   = (lk_tag == head_tag) && (sec_tag == head_tag);
  assign kill     = !tag_ok || sec_drop || (lk_hit && lk_drop);
  assign to_ctrl  = !lk_hit;
  assign lk_pop   = decide;
  assign sec_pop  = decide;
  assign flit_pop = (st != ST_IDLE) && !flit_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      head_tag    <= '0;
      dest_port   <= '0;
      dest_ctrl   <= 1'b0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_last    <= 1'b0;
      out_port    <= '0;
      out_to_ctrl <= 1'b0;
    end else begin
      out_valid <= (st == ST_SEND) && !flit_empty;
      if ((st == ST_SEND) && !flit_empty) begin
        out_data    <= flit_data;
        out_last    <= flit_last;
        out_port    <= dest_port;
        out_to_ctrl <= dest_ctrl;
      end
      case (st)
        ST_IDLE: begin
          if (decide) begin
            st        <= kill ? ST_DISCARD : ST_SEND;
            dest_port <= to_ctrl ? '0 : lk_port;
            dest_ctrl <= to_ctrl;
          end
        end
        ST_SEND, ST_DISCARD: begin
          if (flit_pop && flit_last) begin
            st       <= ST_IDLE;
            head_tag <= head_tag + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/verdict_hold_dispatch.sv
module verdict_hold_dispatch #(
  parameter int FLIT_W    = 16,
  parameter int PKT_DEPTH = 16,
  parameter int VQ_DEPTH  = 4,
  parameter int TAG_W     = 4,
  parameter int N_PORTS   = 4,
  parameter int N_CORES   = 3,
  parameter int PORT_W    = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [FLIT_W-1:0]  in_data,
  input  logic               in_last,
  output logic               in_ready,
  input  logic               lk_valid,
  input  logic [TAG_W-1:0]   lk_tag,
  input  logic               lk_hit,
  input  logic               lk_drop,
  input  logic [PORT_W-1:0]  lk_port,
  output logic               lk_ready,
  input  logic               sec_valid,
  input  logic [TAG_W-1:0]   sec_tag,
  input  logic [N_CORES-1:0] sec_illegal,
  input  logic [N_CORES-1:0] core_en,
  output logic               sec_ready,
  output logic               out_valid,
  output logic [FLIT_W-1:0]  out_data,
  output logic               out_last,
  output logic [PORT_W-1:0]  out_port,
  output logic               out_to_ctrl
);
  localparam int FW = FLIT_W + 1;
  localparam int LW = TAG_W + 2 + PORT_W;
  localparam int SW = TAG_W + 1;

  logic              flit_full, flit_empty, flit_pop;
  logic [FW-1:0]     flit_head;
  logic              lk_full, lk_empty, lk_pop;
  logic [LW-1:0]     lk_head;
  logic              sec_full, sec_empty, sec_pop, merged_drop;
  logic [SW-1:0]     sec_head;

  assign in_ready  = !flit_full;
  assign lk_ready  = !lk_full;
  assign sec_ready = !sec_full;

  hd_fifo #(.W(FW), .DEPTH(PKT_DEPTH)) u_flits (
    .clk(clk), .rst(rst),
    .push(in_valid), .wdata({in_last, in_data}), .full(flit_full),
    .pop(flit_pop), .rdata(flit_head), .empty(flit_empty)
  );

  hd_fifo #(.W(LW), .DEPTH(VQ_DEPTH)) u_lkq (
    .clk(clk), .rst(rst),
    .push(lk_valid), .wdata({lk_tag, lk_hit, lk_drop, lk_port}), .full(lk_full),
    .pop(lk_pop), .rdata(lk_head), .empty(lk_empty)
  );

  hd_vote_merge #(.N_CORES(N_CORES)) u_merge (
    .illegal(sec_illegal), .enable(core_en), .drop(merged_drop)
  );

  hd_fifo #(.W(SW), .DEPTH(VQ_DEPTH)) u_secq (
    .clk(clk), .rst(rst),
    .push(sec_valid), .wdata({sec_tag, merged_drop}), .full(sec_full),
    .pop(sec_pop), .rdata(sec_head), .empty(sec_empty)
  );

  hd_dispatch #(.FLIT_W(FLIT_W), .TAG_W(TAG_W), .PORT_W(PORT_W)) u_disp (
    .clk(clk), .rst(rst),
    .lk_empty(lk_empty),
    .lk_tag(lk_head[LW-1 -: TAG_W]),
    .lk_hit(lk_head[PORT_W+1]),
    .lk_drop(lk_head[PORT_W]),
    .lk_port(lk_head[PORT_W-1:0]),
    .lk_pop(lk_pop),
    .sec_empty(sec_empty),
    .sec_tag(sec_head[SW-1:1]),
    .sec_drop(sec_head[0]),
    .sec_pop(sec_pop),
    .flit_empty(flit_empty),
    .flit_data(flit_head[FLIT_W-1:0]),
    .flit_last(flit_head[FLIT_W]),
    .flit_pop(flit_pop),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_port(out_port), .out_to_ctrl(out_to_ctrl)
  );
endmodule

// File: rtl/verdict_hold_dispatch_chk.sv
module verdict_hold_dispatch_chk #(
  parameter int PORT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              lk_ready,
  input logic              sec_ready,
  input logic              out_valid,
  input logic              out_last,
  input logic [PORT_W-1:0] out_port,
  input logic              out_to_ctrl
);
  logic [15:0] in_cnt, out_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cnt  <= '0;
      out_cnt <= '0;
    end else begin
      if (in_valid && in_ready) in_cnt  <= in_cnt + 1'b1;
      if (out_valid)            out_cnt <= out_cnt + 1'b1;
    end
  end

  // R1: reset leaves the output idle and every queue open
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready && lk_ready && sec_ready));

  // R5: no more flits leave than have entered
  a_r5_out_never_exceeds_in: assert property (@(posedge clk) disable iff (rst)
    out_cnt <= in_cnt);

  // R8: controller-bound flits carry port index zero
  a_r8_ctrl_port_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_to_ctrl) |-> (out_port == '0));

  // R12: destination is held across the flits of one packet
  a_r12_dest_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> (!out_valid || ($stable(out_port) && $stable(out_to_ctrl))));
endmodule

bind verdict_hold_dispatch verdict_hold_dispatch_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .lk_ready(lk_ready), .sec_ready(sec_ready), .out_valid(out_valid),
  .out_last(out_last), .out_port(out_port), .out_to_ctrl(out_to_ctrl)
);

// File: tb/verdict_hold_dispatch_tb.sv
module verdict_hold_dispatch_tb;
  localparam int FLIT_W = 16, PKT_DEPTH = 16, TAG_W = 4, PORT_W = 2, NC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic              in_valid = 0, in_last = 0, in_ready;
  logic [FLIT_W-1:0] in_data = '0;
  logic              lk_valid = 0, lk_hit = 0, lk_drop = 0, lk_ready;
  logic [TAG_W-1:0]  lk_tag = '0, sec_tag = '0;
  logic [PORT_W-1:0] lk_port = '0;
  logic              sec_valid = 0, sec_ready;
  logic [NC-1:0]     sec_illegal = '0, core_en = '1;
  logic              out_valid, out_last, out_to_ctrl;
  logic [FLIT_W-1:0] out_data;
  logic [PORT_W-1:0] out_port;

  verdict_hold_dispatch #(.FLIT_W(FLIT_W), .PKT_DEPTH(PKT_DEPTH), .VQ_DEPTH(4),
    .TAG_W(TAG_W), .N_PORTS(4), .N_CORES(NC)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_hit(lk_hit),
    .lk_drop(lk_drop), .lk_port(lk_port), .lk_ready(lk_ready), .sec_valid(sec_valid),
    .sec_tag(sec_tag), .sec_illegal(sec_illegal), .core_en(core_en), .sec_ready(sec_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_port(out_port),
    .out_to_ctrl(out_to_ctrl));

  int checks = 0, errors = 0;
  int cap_n = 0;
  logic [FLIT_W-1:0] cap_data [256];
  logic              cap_last [256];
  logic [PORT_W-1:0] cap_port [256];
  logic              cap_ctrl [256];
  logic [TAG_W-1:0]  tag_ctr = '0;

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      cap_data[cap_n[7:0]] <= out_data;
      cap_last[cap_n[7:0]] <= out_last;
      cap_port[cap_n[7:0]] <= out_port;
      cap_ctrl[cap_n[7:0]] <= out_to_ctrl;
      cap_n <= cap_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_pkt(input int id, input int len);
    for (int f = 0; f < len; f++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = {id[7:0], f[7:0]};
      in_last  = (f == len - 1);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic push_verdicts(input logic [TAG_W-1:0] lt, input logic [TAG_W-1:0] st,
      input logic hit, input logic adrop, input logic [PORT_W-1:0] port,
      input logic [NC-1:0] votes, input logic [NC-1:0] en);
    @(negedge clk);
    lk_valid = 1'b1; lk_tag = lt; lk_hit = hit; lk_drop = adrop; lk_port = port;
    sec_valid = 1'b1; sec_tag = st; sec_illegal = votes; core_en = en;
    while (!(lk_ready && sec_ready)) @(negedge clk);
    @(negedge clk);
    lk_valid = 1'b0; sec_valid = 1'b0;
  endtask

  task automatic expect_pkt(input int base, input int id, input int len, input int port,
      input bit ctrl, input string req);
    bit ok = 1'b1;
    for (int f = 0; f < len; f++) begin
      if (cap_data[base+f] != {id[7:0], f[7:0]}) ok = 1'b0;
      if (cap_last[base+f] != (f == len - 1)) ok = 1'b0;
      if (cap_port[base+f] != port[PORT_W-1:0]) ok = 1'b0;
      if (cap_ctrl[base+f] != ctrl) ok = 1'b0;
    end
    check(ok, req, int'(cap_data[base]), int'({id[7:0], 8'd0}));
  endtask

  // row: {len[13:10], hit[9], act_drop[8], port[7:6], votes[5:3], enable[2:0]}
  localparam logic [13:0] VEC [8] = '{
    {4'd3, 1'b1, 1'b0, 2'd2, 3'b000, 3'b111},
    {4'd1, 1'b1, 1'b0, 2'd1, 3'b010, 3'b111},
    {4'd4, 1'b0, 1'b0, 2'd3, 3'b000, 3'b111},
    {4'd2, 1'b1, 1'b1, 2'd3, 3'b000, 3'b111},
    {4'd2, 1'b1, 1'b0, 2'd3, 3'b100, 3'b011},
    {4'd5, 1'b0, 1'b0, 2'd0, 3'b001, 3'b111},
    {4'd1, 1'b1, 1'b0, 2'd0, 3'b000, 3'b111},
    {4'd3, 1'b1, 1'b0, 2'd1, 3'b110, 3'b000}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int base;
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready && lk_ready && sec_ready, "R1 reset state",
          {out_valid, in_ready, lk_ready, sec_ready}, 4'b0111);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 after reset", {out_valid, in_ready}, 2'b01);

    for (int r = 0; r < 8; r++) begin
      int len; bit hit, adrop, kill, ctrl; int port; logic [NC-1:0] v, e;
      len = int'(VEC[r][13:10]); hit = VEC[r][9]; adrop = VEC[r][8];
      port = int'(VEC[r][7:6]); v = VEC[r][5:3]; e = VEC[r][2:0];
      kill = (|(v & e)) || (hit && adrop);
      ctrl = !hit;
      base = cap_n;
      if (r % 2 == 1) begin
        push_verdicts(tag_ctr, tag_ctr, hit, adrop, port[PORT_W-1:0], v, e);
        send_pkt(r, len);
      end else begin
        send_pkt(r, len);
        push_verdicts(tag_ctr, tag_ctr, hit, adrop, port[PORT_W-1:0], v, e);
      end
      tag_ctr++;
      repeat (len + 8) @(negedge clk);
      // R3 R4 R5 R7 R9: flit count follows the merged decision
      check(cap_n - base == (kill ? 0 : len), "R3/R4/R5/R7/R9 flit count",
            cap_n - base, kill ? 0 : len);
      if (!kill)
        expect_pkt(base, r, len, ctrl ? 0 : port, ctrl, ctrl ? "R8 controller" : "R6 forward");
    end

    // R11: two-cycle start once both decisions are in
    base = cap_n;
    send_pkt(20, 3);
    repeat (3) @(negedge clk);
    lk_valid = 1; lk_tag = tag_ctr; lk_hit = 1; lk_drop = 0; lk_port = 2'd3;
    sec_valid = 1; sec_tag = tag_ctr; sec_illegal = '0; core_en = '1;
    @(negedge clk);
    lk_valid = 0; sec_valid = 0;
    @(negedge clk);
    check(!out_valid, "R11 not yet after one cycle", out_valid, 0);
    @(negedge clk);
    check(out_valid, "R11 first flit after two cycles", out_valid, 1);
    tag_ctr++;
    repeat (6) @(negedge clk);
    expect_pkt(base, 20, 3, 3, 1'b0, "R11 packet intact");

    // R9: three packets buffered, then three decision pairs in order
    base = cap_n;
    send_pkt(30, 2); send_pkt(31, 2); send_pkt(32, 2);
    push_verdicts(tag_ctr, tag_ctr, 1, 0, 2'd1, '0, '1);
    push_verdicts(tag_ctr + 4'd1, tag_ctr + 4'd1, 0, 0, 2'd2, '0, '1);
    push_verdicts(tag_ctr + 4'd2, tag_ctr + 4'd2, 1, 0, 2'd2, '0, '1);
    tag_ctr = tag_ctr + 4'd3;
    repeat (15) @(negedge clk);
    check(cap_n - base == 6, "R9 queued flit count", cap_n - base, 6);
    expect_pkt(base, 30, 2, 1, 1'b0, "R9 first pair");
    expect_pkt(base + 2, 31, 2, 0, 1'b1, "R9 second pair");
    expect_pkt(base + 4, 32, 2, 2, 1'b0, "R9 third pair");

    // R10: wrong lookup tag discards, numbering continues
    base = cap_n;
    send_pkt(40, 2);
    push_verdicts(tag_ctr + 4'd5, tag_ctr, 1, 0, 2'd1, '0, '1);
    tag_ctr++;
    repeat (10) @(negedge clk);
    check(cap_n == base, "R10 tag mismatch discards", cap_n - base, 0);
    send_pkt(41, 2);
    push_verdicts(tag_ctr, tag_ctr, 1, 0, 2'd2, '0, '1);
    tag_ctr++;
    repeat (10) @(negedge clk);
    check(cap_n - base == 2, "R10 next tag accepted", cap_n - base, 2);
    expect_pkt(base, 41, 2, 2, 1'b0, "R10 next packet");

    // R2: full FIFO blocks and ignores pushes
    base = cap_n;
    send_pkt(50, PKT_DEPTH);
    check(!in_ready, "R2 ready low when full", in_ready, 0);
    in_valid = 1; in_data = 16'hBEEF; in_last = 1;
    repeat (3) @(negedge clk);
    in_valid = 0; in_last = 0;
    push_verdicts(tag_ctr, tag_ctr, 1, 0, 2'd1, '0, '1);
    tag_ctr++;
    repeat (30) @(negedge clk);
    check(cap_n - base == PKT_DEPTH, "R2 blocked flit ignored", cap_n - base, PKT_DEPTH);
    expect_pkt(base, 50, PKT_DEPTH, 1, 1'b0, "R2 full packet");
    check(in_ready, "R2 ready after drain", in_ready, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule